// File: doc/BRIEF.md
# Address-As-Data Memory Tester

This block is a self-test engine for a memory made of 32-bit words and addressed in bytes. On a start pulse it captures a start and an end byte address and fills that inclusive range with data derived from each word's own address. It then reads the whole range back and compares every word with the value it should hold. The data cycles through three forms, selected by the word's position counted from the start address modulo three: the plain address, its bitwise complement, and the address with its two 16-bit halves exchanged. A second pass repeats the fill and the check with every data word inverted, so each data bit is tested at both levels.

The engine drives a synchronous single-port memory directly. A read request made in one cycle returns its data in the next cycle. The engine stops at the first word that reads back wrong. It reports the byte address, the word it expected and the word it got, and raises fail together with done. A range whose end lies below its start finishes at once and reports a pass without touching the memory.

Top module: `aad_mem_bist`

## Requirements
- R1: While reset is held and in the first cycle after it is released, done, fail and memEn are 0.
- R2: Every access uses a word-aligned byte address with bits [1:0] = 0. Consecutive writes, and consecutive reads, step the address up by 4. Bits [1:0] of startAddr and endAddr are ignored, and endAddr names the last word of the range, which is included.
- R3: The word at index k from the start (k = 0, 1, 2, ...) with byte address A holds A when k mod 3 = 0, ~A when k mod 3 = 1, and {A[15:0], A[31:16]} when k mod 3 = 2.
- R4: Each pass first writes the whole range and then reads the whole range back, comparing each word against its value from R3.
- R5: A second pass repeats R4 with every data word XORed with all ones. After a run with no error, each word in the range holds the inverted value from R3.
- R6: On the first miscompare the engine raises done and fail together. failAddr, failExp and failAct hold the byte address, the expected word and the word read back. No memory access follows.
- R7: If the word part of endAddr is below the word part of startAddr, done rises with fail = 0 in the cycle after the start pulse, and no memory access is made.
- R8: done, fail and the three failure fields hold their values until the next start pulse. A start pulse that arrives while a run is in progress is ignored.
- R9: Read data is compared in the cycle after its read request, as the memory delivers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin a run |
| startAddr | input | 32 | Byte address of the first word |
| endAddr | input | 32 | Byte address of the last word (inclusive) |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read, valid with memEn |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid one cycle after a read request |
| done | output | 1 | Run finished |
| fail | output | 1 | Run finished on a miscompare |
| failAddr | output | 32 | Byte address of the first bad word |
| failExp | output | 32 | Value expected at that word |
| failAct | output | 32 | Value read back from that word |

## Verification
On every cycle the assertions check that the memory falls silent once done is high, that fail never appears without done, and that every access address is word aligned. They also check that back-to-back writes or reads advance by exactly one word, and that the result outputs stay frozen between start pulses. Only the bench's scenarios can show the data side. That covers the three-way address pattern and its inversion as they land in memory, the choice of pass in which a stuck bit is caught, the values latched for the bad word, the empty-range and single-word cases, the discarding of a start pulse that arrives mid-run, and the masking of the low address bits.

// File: rtl/aad_bist_pkg.sv
package aad_bist_pkg;

  // number of data forms that the address-derived pattern cycles through
  localparam int PAT_LEN = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_FIN
  } bistState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRange;  // capture range inputs and point at the first word
    logic rewind;     // point back at the first word
    logic setInvert;  // second pass: invert data
    logic clrInvert;  // first pass: plain data
    logic issueWr;    // write current word, then advance
    logic issueRd;    // read current word, then advance
    logic latchFail;  // capture the miscompare details
    logic clrResult;  // clear the failure fields
  } dpCtrl_t;

endpackage

// File: rtl/aad_bist_dp.sv
module aad_bist_dp
  import aad_bist_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [WORD_W-1:0] startAddr,
  input  logic [WORD_W-1:0] endAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              atEnd,
  output logic              rangeEmpty,
  output logic              mismatch,
  output logic [WORD_W-1:0] failAddr,
  output logic [WORD_W-1:0] failExp,
  output logic [WORD_W-1:0] failAct
);

  localparam int BYTES     = WORD_W / 8;
  localparam int LANE_BITS = $clog2(BYTES);
  localparam int HALF_W    = WORD_W / 2;
  localparam int IDX_W     = $clog2(PAT_LEN);
  localparam logic [WORD_W-1:0]   STEP    = WORD_W'(BYTES);
  localparam logic [IDX_W-1:0]    IDX_TOP = IDX_W'(PAT_LEN - 1);
  localparam logic [LANE_BITS-1:0] LANE_Z = '0;

  function automatic logic [WORD_W-1:0] patWord(input logic [WORD_W-1:0] a,
                                                input logic [IDX_W-1:0]  sel,
                                                input logic              inv);
    logic [WORD_W-1:0] r;
    if (sel == IDX_W'(0))      r = a;
    else if (sel == IDX_W'(1)) r = ~a;
    else                       r = {a[HALF_W-1:0], a[WORD_W-1:HALF_W]};
    return r ^ {WORD_W{inv}};
  endfunction

  logic [WORD_W-1:0] startReg, endReg, curAddr;
  logic [WORD_W-1:0] startWord, endWord;
  logic [IDX_W-1:0]  patIdx;
  logic              invert;
  logic [WORD_W-1:0] curPat;

  logic              cmpValid;
  logic [WORD_W-1:0] cmpExp, cmpAddr;

  assign startWord  = {startAddr[WORD_W-1:LANE_BITS], LANE_Z};
  assign endWord    = {endAddr[WORD_W-1:LANE_BITS], LANE_Z};
  assign rangeEmpty = endAddr[WORD_W-1:LANE_BITS] < startAddr[WORD_W-1:LANE_BITS];
  assign atEnd      = (curAddr == endReg);
  assign curPat     = patWord(curAddr, patIdx, invert);

  assign memEn    = ctl.issueWr | ctl.issueRd;
  assign memWe    = ctl.issueWr;
  assign memAddr  = curAddr;
  assign memWdata = curPat;

  assign mismatch = cmpValid && (memRdata != cmpExp);

  // address walker and pattern position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startReg <= '0;
      endReg   <= '0;
      curAddr  <= '0;
      patIdx   <= '0;
    end else if (ctl.loadRange) begin
      startReg <= startWord;
      endReg   <= endWord;
      curAddr  <= startWord;
      patIdx   <= '0;
    end else if (ctl.rewind) begin
      curAddr  <= startReg;
      patIdx   <= '0;
    end else if (ctl.issueWr || ctl.issueRd) begin
      curAddr  <= curAddr + STEP;
      patIdx   <= (patIdx == IDX_TOP) ? '0 : patIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             invert <= 1'b0;
    else if (ctl.clrInvert) invert <= 1'b0;
    else if (ctl.setInvert) invert <= 1'b1;
  end

  // one-stage compare pipe matching the memory read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpValid <= 1'b0;
      cmpExp   <= '0;
      cmpAddr  <= '0;
    end else begin
      cmpValid <= ctl.issueRd;
      cmpExp   <= curPat;
      cmpAddr  <= curAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrResult) begin
      failAddr <= '0;
      failExp  <= '0;
      failAct  <= '0;
    end else if (ctl.latchFail) begin
      failAddr <= cmpAddr;
      failExp  <= cmpExp;
      failAct  <= memRdata;
    end
  end

endmodule

// File: rtl/aad_bist_ctrl.sv
module aad_bist_ctrl
  import aad_bist_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startPulse,
  input  logic    atEnd,
  input  logic    rangeEmpty,
  input  logic    mismatch,
  output dpCtrl_t ctl,
  output logic    done,
  output logic    fail
);

  bistState_t state, stateNext;
  logic       secondPass, secondPassNext;
  logic       failNext;

  always_comb begin
    ctl            = '0;
    stateNext      = state;
    secondPassNext = secondPass;
    failNext       = fail;
    unique case (state)
      ST_IDLE, ST_FIN: begin
        if (startPulse) begin
          ctl.clrResult  = 1'b1;
          ctl.loadRange  = 1'b1;
          ctl.clrInvert  = 1'b1;
          secondPassNext = 1'b0;
          failNext       = 1'b0;
          stateNext      = rangeEmpty ? ST_FIN : ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl.issueWr = 1'b1;
        if (atEnd) begin
          ctl.rewind = 1'b1;
          stateNext  = ST_READ;
        end
      end
      ST_READ: begin
        if (mismatch) begin
          ctl.latchFail = 1'b1;
          failNext      = 1'b1;
          stateNext     = ST_FIN;
        end else begin
          ctl.issueRd = 1'b1;
          if (atEnd) stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (mismatch) begin
          ctl.latchFail = 1'b1;
          failNext      = 1'b1;
          stateNext     = ST_FIN;
        end else if (!secondPass) begin
          ctl.rewind     = 1'b1;
          ctl.setInvert  = 1'b1;
          secondPassNext = 1'b1;
          stateNext      = ST_WRITE;
        end else begin
          stateNext = ST_FIN;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      secondPass <= 1'b0;
      fail       <= 1'b0;
    end else begin
      state      <= stateNext;
      secondPass <= secondPassNext;
      fail       <= failNext;
    end
  end

  assign done = (state == ST_FIN);

endmodule

// File: rtl/aad_mem_bist.sv
module aad_mem_bist
  import aad_bist_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [WORD_W-1:0] startAddr,
  input  logic [WORD_W-1:0] endAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              done,
  output logic              fail,
  output logic [WORD_W-1:0] failAddr,
  output logic [WORD_W-1:0] failExp,
  output logic [WORD_W-1:0] failAct
);

  dpCtrl_t ctl;
  logic    atEnd, rangeEmpty, mismatch;

  aad_bist_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .atEnd      (atEnd),
    .rangeEmpty (rangeEmpty),
    .mismatch   (mismatch),
    .ctl        (ctl),
    .done       (done),
    .fail       (fail)
  );

  aad_bist_dp #(.WORD_W(WORD_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .startAddr  (startAddr),
    .endAddr    (endAddr),
    .memRdata   (memRdata),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .atEnd      (atEnd),
    .rangeEmpty (rangeEmpty),
    .mismatch   (mismatch),
    .failAddr   (failAddr),
    .failExp    (failExp),
    .failAct    (failAct)
  );

endmodule

// File: rtl/aad_mem_bist_chk.sv
module aad_mem_bist_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startPulse,
  input logic              memEn,
  input logic              memWe,
  input logic [WORD_W-1:0] memAddr,
  input logic              done,
  input logic              fail,
  input logic [WORD_W-1:0] failAddr
);

  localparam int BYTES     = WORD_W / 8;
  localparam int LANE_BITS = $clog2(BYTES);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(BYTES);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !memEn);

  // R6
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memEn |-> (memAddr[LANE_BITS-1:0] == '0));

  // R2
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memEn && memWe && $past(memEn && memWe)) |-> (memAddr == $past(memAddr) + STEP));

  // R2
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memEn && !memWe && $past(memEn && !memWe)) |-> (memAddr == $past(memAddr) + STEP));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done) && !$past(startPulse)) |-> ($stable(fail) && $stable(failAddr)));

endmodule

bind aad_mem_bist aad_mem_bist_chk #(.WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .startPulse (startPulse),
  .memEn      (memEn),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .done       (done),
  .fail       (fail),
  .failAddr   (failAddr)
);

// File: tb/aad_mem_bist_tb_top.sv
module aad_mem_bist_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] startAddr = '0, endAddr = '0;
  logic        memEn, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        done, fail;
  logic [31:0] failAddr, failExp, failAct;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int accCnt = 0;
  int lateAcc = 0;

  logic [31:0] mem [256];
  logic [31:0] faultAddr = '0;
  logic [31:0] faultMask = '0;

  always #2 clk = ~clk;  // 250 MHz

  aad_mem_bist dut_i (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse),
    .startAddr(startAddr), .endAddr(endAddr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .done(done), .fail(fail),
    .failAddr(failAddr), .failExp(failExp), .failAct(failAct)
  );

  // synchronous memory with an optional stuck-at-one fault
  always @(posedge clk) begin
    if (memEn && memWe)
      mem[memAddr[9:2]] <= memWdata | ((memAddr == faultAddr) ? faultMask : 32'h0);
    if (memEn && !memWe)
      memRdata <= mem[memAddr[9:2]];
    if (memEn) accCnt <= accCnt + 1;
    if (memEn && done) lateAcc <= lateAcc + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL R6 watchdog: cycles=%0d expected<=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] expPat(input logic [31:0] a, input int k, input bit inv);
    logic [31:0] r;
    case (k % 3)
      0: r = a;
      1: r = ~a;
      default: r = {a[15:0], a[31:16]};
    endcase
    return inv ? ~r : r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic fillMem(input logic [31:0] v);
    for (int i = 0; i < 256; i++) mem[i] = v;
  endtask

  task automatic pulseStart(input logic [31:0] s, input logic [31:0] e);
    @(negedge clk);
    startAddr  = s;
    endAddr    = e;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  // one run: the expected outcome is derived from the requirements only
  task automatic runCase(input logic [31:0] s, input logic [31:0] e,
                         input logic [31:0] fA, input logic [31:0] fM);
    logic [31:0] sw, ew, a, w, eAddr, eExp, eAct;
    int n, bad;
    bit found;
    sw = {s[31:2], 2'b00};
    ew = {e[31:2], 2'b00};
    n = int'((ew - sw) >> 2) + 1;
    found = 0; eAddr = '0; eExp = '0; eAct = '0;
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < n; k++) begin
        a = sw + 32'(4 * k);
        w = expPat(a, k, p == 1);
        if (!found && a == fA && ((w | fM) != w)) begin
          found = 1; eAddr = a; eExp = w; eAct = w | fM;
        end
      end
    fillMem(32'hDEAD_BEEF);
    faultAddr = fA;
    faultMask = fM;
    lateAcc = 0;
    pulseStart(s, e);
    waitDone();
    chk(done == 1'b1, "R4", "done after run", 32'(done), 32'h1);
    chk(fail == found, "R6", "fail flag", 32'(fail), 32'(found));
    if (found) begin
      chk(failAddr == eAddr, "R6", "failAddr", failAddr, eAddr);
      chk(failExp == eExp, "R5", "failExp", failExp, eExp);
      chk(failAct == eAct, "R6", "failAct", failAct, eAct);
    end else begin
      bad = 0;
      for (int k = 0; k < n; k++) begin
        a = sw + 32'(4 * k);
        if (mem[a[9:2]] !== expPat(a, k, 1)) bad++;
      end
      chk(bad == 0, "R5", "words differing from inverted R3 pattern", 32'(bad), 32'h0);
    end
    repeat (4) @(negedge clk);
    chk(lateAcc == 0, "R6", "accesses after done", 32'(lateAcc), 32'h0);
  endtask

  // {start, end, fault address, stuck-at-one mask}
  localparam logic [127:0] VEC [6] = '{
    {32'h4000_0100, 32'h4000_0140, 32'h0, 32'h0},
    {32'h1234_0000, 32'h1234_00FC, 32'h0, 32'h0},
    {32'h4000_0100, 32'h4000_0140, 32'h4000_0108, 32'h0000_0001},
    {32'h4000_0100, 32'h4000_0140, 32'h4000_0104, 32'h0000_0001},
    {32'h4000_0203, 32'h4000_0211, 32'h0, 32'h0},
    {32'h4000_0300, 32'h4000_0300, 32'h4000_0300, 32'h8000_0000}
  };

  initial begin
    logic [31:0] a, heldAddr;
    int bad, acc0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && fail == 1'b0 && memEn == 1'b0, "R1", "outputs in reset",
        {29'h0, done, fail, memEn}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && fail == 1'b0 && memEn == 1'b0, "R1", "outputs after reset",
        {29'h0, done, fail, memEn}, 32'h0);

    // R2 R3 R4 R5 R6 R9: table of ranges and faults
    for (int v = 0; v < 6; v++)
      runCase(VEC[v][127:96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);

    // R8: results held while idle after a failing run
    heldAddr = failAddr;
    repeat (10) @(negedge clk);
    chk(done && fail && failAddr == heldAddr, "R8", "held failAddr", failAddr, heldAddr);

    // R7: empty range finishes next cycle with pass and no access
    faultMask = '0;
    acc0 = accCnt;
    @(negedge clk);
    startAddr = 32'h4000_0200; endAddr = 32'h4000_01FC; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(done == 1'b1 && fail == 1'b0, "R7", "done pass after empty start",
        {30'h0, done, fail}, 32'h2);
    repeat (3) @(negedge clk);
    chk(accCnt == acc0, "R7", "accesses for empty range", 32'(accCnt - acc0), 32'h0);

    // R8: start during a run is ignored
    fillMem(32'hDEAD_BEEF);
    for (int i = 8'hE0; i < 8'hF0; i++) mem[i] = 32'h5A5A_5A5A;
    pulseStart(32'h4000_0100, 32'h4000_0120);
    repeat (3) @(negedge clk);
    pulseStart(32'h4000_0380, 32'h4000_03BC);
    waitDone();
    chk(done && !fail, "R8", "run completes despite second start", {30'h0, done, fail}, 32'h2);
    bad = 0;
    for (int i = 8'hE0; i < 8'hF0; i++) if (mem[i] !== 32'h5A5A_5A5A) bad++;
    chk(bad == 0, "R8", "words touched in ignored range", 32'(bad), 32'h0);
    bad = 0;
    for (int k = 0; k < 9; k++) begin
      a = 32'h4000_0100 + 32'(4 * k);
      if (mem[a[9:2]] !== expPat(a, k, 1)) bad++;
    end
    chk(bad == 0, "R3", "first range words after busy start", 32'(bad), 32'h0);

    // R1: reset in the middle of a run clears the result
    pulseStart(32'h4000_0100, 32'h4000_01FC);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fail && !memEn, "R1", "outputs after mid-run reset",
        {29'h0, done, fail, memEn}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule